// File: doc/BRIEF.md
# CPU Clock Stop and Power-Down Controller

This block decides, for each of a small set of differential CPU clock pairs, whether the pair runs, parks at a driven level, or floats. Two asynchronous pins steer it. One is an active-low stop request that parks the pairs marked as stoppable. The other is a shared pin. Before the supply is declared good, it acts as an active-low power-good strobe. After that, it acts as an active-high power-down request. Per-pair configuration bits give the output enable, whether the pair can be stopped, and whether a stopped or powered-down pair is driven or tristated.

The first time the strobe is seen low, three frequency-select straps and a debug-port enable strap are captured and held, and the selected CPU frequency is decoded. A power-down parks every pair before the oscillator enable drops. On exit the oscillator is re-enabled, and the pairs stay parked for a programmable settling count before they run again. Analog drive levels are not modelled: each pair reports a two-bit state code plus the logic level of its true and complement legs.

A power sequencer runs through these states:
- `PW_STRAP`: waiting for power-good.
- `PW_WARM`: oscillator on, pairs parked while the settling count runs.
- `PW_RUN`: normal operation.
- `PW_PD_PARK`: pairs parked, oscillator still on.
- `PW_VCO_OFF`: oscillator off.

Its transitions are:
- strobe seen low: STRAP→WARM
- settle count reached: WARM→RUN
- power-down seen: RUN→PD_PARK
- park window elapsed: PD_PARK→VCO_OFF
- power-down released: VCO_OFF→WARM
- power-down seen again: WARM→VCO_OFF

Top module: `cpu_clk_gate_ctrl`

## Requirements
- R1: The first time the synchronized shared pin is low after reset, `fs_strap_i` and `itp_strap_i` are captured and `straps_valid_o` goes high. `cpu_mhz_o` decodes the captured code as follows: 3'b000=266, 3'b001=133, 3'b010=200, 3'b011=166, 3'b100=333, 3'b101=100, 3'b110=400, 3'b111=0 (reserved).
- R2: Until the straps are captured, `vco_en_o` is 0 and every pair reports tristate. The state codes are 2'b00 run, 2'b01 driven stop, 2'b10 driven power-down and 2'b11 tristate. Each pair's code sits in `pair_state_o[2*i+1:2*i]`.
- R3: After capture the oscillator is enabled, and the pairs hold their power-down state for exactly `stab_cnt_i`+1 sampled cycles with `vco_en_o` high before they run.
- R4: A running, enabled pair toggles `clk_t_o` on every clock, with `clk_c_o` its inverse.
- R5: While stop is requested, an enabled stoppable pair parks, but only after its true leg has been high. It reports driven stop with true=1, complement=0 when its stop-tristate bit is 0, and tristate (both legs 0) when that bit is 1.
- R6: An enabled pair whose stoppable bit is 0 keeps running while stop is requested.
- R7: After the stop pin is released, every parked pair is running again within 2 to 6 clocks. Its first running level is true=0.
- R8: On power-down, enabled pairs report driven power-down (true=1, complement=0) when their power-down-tristate bit is 0, or tristate when it is 1. All pairs are in that state at least one sampled cycle before `vco_en_o` falls, which happens within 8 clocks.
- R9: Power-down overrides stop: during power-down a pair's state depends only on its enable and power-down-tristate bits.
- R10: A pair whose `oe_i` bit is 0 reports tristate with both legs 0, whatever the stop, power-down and tristate bits are.
- R11: When power-down is released, `vco_en_o` returns high, and the pairs hold their power-down state for exactly `stab_cnt_i`+1 sampled cycles before running.
- R12: After capture, the shared pin acts only as the power-down request, and later strap changes do not alter `fs_latched_o` or `cpu_mhz_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pgpd_i | input | 1 | Shared pin: active-low power-good strobe, then active-high power-down |
| stop_ni | input | 1 | Asynchronous active-low CPU stop request |
| fs_strap_i | input | 3 | Frequency-select straps |
| itp_strap_i | input | 1 | Debug-port enable strap |
| stab_cnt_i | input | STAB_W | Settling count after the oscillator is re-enabled |
| oe_i | input | N_OUT | Per-pair output enable |
| stoppable_i | input | N_OUT | Per-pair: parks on stop request |
| stop_tri_i | input | N_OUT | Per-pair: tristate instead of driven when stopped |
| pd_tri_i | input | N_OUT | Per-pair: tristate instead of driven in power-down |
| pair_state_o | output | 2*N_OUT | Per-pair state code |
| clk_t_o | output | N_OUT | True-leg logic level |
| clk_c_o | output | N_OUT | Complement-leg logic level |
| vco_en_o | output | 1 | Oscillator enable |
| straps_valid_o | output | 1 | Straps have been captured |
| fs_latched_o | output | 3 | Captured frequency-select code |
| itp_en_o | output | 1 | Captured debug-port enable |
| cpu_mhz_o | output | 9 | Decoded CPU frequency in MHz, 0 if reserved |

## Verification
A wrong sequencer state shows up at the ports within one clock of the next pin event, in one of three ways:
- the oscillator enable drops while a pair still reports running;
- a pair leaves its parked state before the settling count expires;
- a pair fails to return from power-down at all.

A corrupted per-pair parked flag shows up as a state code that disagrees with the enable, stoppable and tristate bits a few clocks after the stop pin moves. It can also show up as a park that starts from a low true leg, which makes the true leg glitch. The bench sweeps sixteen per-pair bit combinations through stop, resume, power-down and re-entry, and sweeps all eight strap codes. Each pair's expected state is computed from its bits, and the bench counts the exact number of settling cycles.

// File: rtl/cpu_gate_pkg.sv
package cpu_gate_pkg;

    typedef enum logic [1:0] {
        PS_RUN      = 2'b00,
        PS_STOP_DRV = 2'b01,
        PS_PD_DRV   = 2'b10,
        PS_TRI      = 2'b11
    } pair_state_e;

    typedef enum logic [2:0] {
        PW_STRAP   = 3'd0,
        PW_WARM    = 3'd1,
        PW_RUN     = 3'd2,
        PW_PD_PARK = 3'd3,
        PW_VCO_OFF = 3'd4
    } pwr_state_e;

    function automatic logic [8:0] fs_to_mhz(input logic [2:0] fs);
        logic [8:0] mhz;
        unique case (fs)
            3'b101:  mhz = 9'd100;
            3'b001:  mhz = 9'd133;
            3'b011:  mhz = 9'd166;
            3'b010:  mhz = 9'd200;
            3'b000:  mhz = 9'd266;
            3'b100:  mhz = 9'd333;
            3'b110:  mhz = 9'd400;
            default: mhz = 9'd0;
        endcase
        return mhz;
    endfunction

endpackage

// File: rtl/cpu_ctl_sync.sv
module cpu_ctl_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/cpu_pwr_fsm.sv
module cpu_pwr_fsm
    import cpu_gate_pkg::*;
#(
    parameter int STAB_W   = 8,
    parameter int PARK_CYC = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pin_s_i,
    input  logic [STAB_W-1:0] stab_cnt_i,
    output logic              vco_en_o,
    output logic              hold_pd_o,
    output logic              pre_good_o,
    output logic              latch_o
);
    localparam int PARK_W = $clog2(PARK_CYC + 1);
    localparam int CNT_W  = (STAB_W > PARK_W) ? STAB_W : PARK_W;
    localparam logic [CNT_W-1:0] PARK_LAST = CNT_W'(PARK_CYC - 1);

    pwr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             counting;

    assign counting = (st_q == PW_WARM) || (st_q == PW_PD_PARK);

    // state register and dwell counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= PW_STRAP;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q)
                cnt_q <= '0;
            else if (counting)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PW_STRAP:   if (!pin_s_i) st_d = PW_WARM;
            PW_WARM: begin
                if (pin_s_i)
                    st_d = PW_VCO_OFF;
                else if (cnt_q >= CNT_W'(stab_cnt_i))
                    st_d = PW_RUN;
            end
            PW_RUN:     if (pin_s_i) st_d = PW_PD_PARK;
            PW_PD_PARK: if (cnt_q >= PARK_LAST) st_d = PW_VCO_OFF;
            PW_VCO_OFF: if (!pin_s_i) st_d = PW_WARM;
            default:    st_d = PW_STRAP;
        endcase
    end

    // outputs
    always_comb begin
        vco_en_o   = 1'b0;
        hold_pd_o  = 1'b0;
        pre_good_o = 1'b0;
        latch_o    = 1'b0;
        unique case (st_q)
            PW_STRAP: begin
                pre_good_o = 1'b1;
                latch_o    = !pin_s_i;
            end
            PW_WARM: begin
                vco_en_o  = 1'b1;
                hold_pd_o = 1'b1;
            end
            PW_RUN:     vco_en_o = 1'b1;
            PW_PD_PARK: begin
                vco_en_o  = 1'b1;
                hold_pd_o = 1'b1;
            end
            PW_VCO_OFF: hold_pd_o = 1'b1;
            default:    pre_good_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/cpu_strap_latch.sv
module cpu_strap_latch
    import cpu_gate_pkg::*;
#(
    parameter int FS_W = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            latch_i,
    input  logic [FS_W-1:0] fs_i,
    input  logic            itp_i,
    output logic            valid_o,
    output logic [FS_W-1:0] fs_o,
    output logic            itp_o,
    output logic [8:0]      mhz_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            valid_o <= 1'b0;
            fs_o    <= '0;
            itp_o   <= 1'b0;
        end else if (latch_i && !valid_o) begin
            valid_o <= 1'b1;
            fs_o    <= fs_i;
            itp_o   <= itp_i;
        end
    end

    assign mhz_o = valid_o ? fs_to_mhz(fs_o) : 9'd0;
endmodule

// File: rtl/cpu_pair_gate.sv
module cpu_pair_gate
    import cpu_gate_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        phase_i,
    input  logic        vco_en_i,
    input  logic        stop_req_i,
    input  logic        hold_pd_i,
    input  logic        pre_good_i,
    input  logic        oe_i,
    input  logic        stoppable_i,
    input  logic        stop_tri_i,
    input  logic        pd_tri_i,
    output pair_state_e state_o,
    output logic        t_o,
    output logic        c_o,
    output logic        parked_o
);
    logic want_park;

    assign want_park = stop_req_i && stoppable_i;

    // park and release only while the true leg is high, so that the leg never glitches
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            parked_o <= 1'b0;
        else if (vco_en_i && phase_i && (want_park != parked_o))
            parked_o <= want_park;
    end

    always_comb begin
        if (!oe_i || pre_good_i)
            state_o = PS_TRI;
        else if (hold_pd_i)
            state_o = pd_tri_i ? PS_TRI : PS_PD_DRV;
        else if (parked_o)
            state_o = stop_tri_i ? PS_TRI : PS_STOP_DRV;
        else
            state_o = PS_RUN;
    end

    always_comb begin
        unique case (state_o)
            PS_RUN: begin
                t_o = phase_i;
                c_o = !phase_i;
            end
            PS_STOP_DRV, PS_PD_DRV: begin
                t_o = 1'b1;
                c_o = 1'b0;
            end
            default: begin
                t_o = 1'b0;
                c_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cpu_clk_gate_ctrl.sv
module cpu_clk_gate_ctrl
    import cpu_gate_pkg::*;
#(
    parameter int N_OUT    = 3,
    parameter int STAB_W   = 8,
    parameter int PARK_CYC = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                pgpd_i,
    input  logic                stop_ni,
    input  logic [2:0]          fs_strap_i,
    input  logic                itp_strap_i,
    input  logic [STAB_W-1:0]   stab_cnt_i,
    input  logic [N_OUT-1:0]    oe_i,
    input  logic [N_OUT-1:0]    stoppable_i,
    input  logic [N_OUT-1:0]    stop_tri_i,
    input  logic [N_OUT-1:0]    pd_tri_i,
    output logic [2*N_OUT-1:0]  pair_state_o,
    output logic [N_OUT-1:0]    clk_t_o,
    output logic [N_OUT-1:0]    clk_c_o,
    output logic                vco_en_o,
    output logic                straps_valid_o,
    output logic [2:0]          fs_latched_o,
    output logic                itp_en_o,
    output logic [8:0]          cpu_mhz_o
);
    logic [1:0]       pins_s;
    logic             pin_s;
    logic             stop_req;
    logic             hold_pd;
    logic             pre_good;
    logic             latch_pulse;
    logic             phase_q;
    logic [N_OUT-1:0] parked;

    cpu_ctl_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({pgpd_i, stop_ni}),
        .q_o    (pins_s)
    );

    assign pin_s    = pins_s[1];
    assign stop_req = !pins_s[0];

    cpu_pwr_fsm #(.STAB_W(STAB_W), .PARK_CYC(PARK_CYC)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_s_i    (pin_s),
        .stab_cnt_i (stab_cnt_i),
        .vco_en_o   (vco_en_o),
        .hold_pd_o  (hold_pd),
        .pre_good_o (pre_good),
        .latch_o    (latch_pulse)
    );

    cpu_strap_latch #(.FS_W(3)) u_strap (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .latch_i (latch_pulse),
        .fs_i    (fs_strap_i),
        .itp_i   (itp_strap_i),
        .valid_o (straps_valid_o),
        .fs_o    (fs_latched_o),
        .itp_o   (itp_en_o),
        .mhz_o   (cpu_mhz_o)
    );

    // shared reference phase: the oscillator output seen at logic level
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            phase_q <= 1'b0;
        else if (vco_en_o)
            phase_q <= !phase_q;
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_pair
        pair_state_e st;

        cpu_pair_gate u_gate (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .phase_i     (phase_q),
            .vco_en_i    (vco_en_o),
            .stop_req_i  (stop_req),
            .hold_pd_i   (hold_pd),
            .pre_good_i  (pre_good),
            .oe_i        (oe_i[g]),
            .stoppable_i (stoppable_i[g]),
            .stop_tri_i  (stop_tri_i[g]),
            .pd_tri_i    (pd_tri_i[g]),
            .state_o     (st),
            .t_o         (clk_t_o[g]),
            .c_o         (clk_c_o[g]),
            .parked_o    (parked[g])
        );

        assign pair_state_o[2*g +: 2] = st;
    end
endmodule

// File: rtl/cpu_clk_gate_chk.sv
module cpu_clk_gate_chk #(
    parameter int N_OUT = 3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [N_OUT-1:0]   oe_i,
    input logic [2*N_OUT-1:0] pair_state_i,
    input logic [N_OUT-1:0]   t_i,
    input logic [N_OUT-1:0]   c_i,
    input logic               vco_en_i,
    input logic               valid_i,
    input logic [2:0]         fs_i,
    input logic               hold_pd_i,
    input logic               stop_req_i,
    input logic [N_OUT-1:0]   parked_i
);
    logic       any_run;
    logic [3:0] rel_cnt;

    always_comb begin
        any_run = 1'b0;
        for (int i = 0; i < N_OUT; i++)
            if (pair_state_i[2*i +: 2] == 2'b00) any_run = 1'b1;
    end

    // cycles spent with stop released while a pair is still parked and the oscillator runs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            rel_cnt <= '0;
        else if (!stop_req_i && (|parked_i) && vco_en_i)
            rel_cnt <= (rel_cnt == 4'hF) ? rel_cnt : rel_cnt + 1'b1;
        else
            rel_cnt <= '0;
    end

    p_resume_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rel_cnt <= 4'd2);

    p_vco_off_parked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!vco_en_i && valid_i) |-> !any_run);

    p_straps_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && $past(valid_i)) |-> $stable(fs_i));

    p_prestrap_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |-> (!vco_en_i && !any_run));

    for (genvar g = 0; g < N_OUT; g++) begin : g_chk
        p_oe_off_tri_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !oe_i[g] |-> (pair_state_i[2*g +: 2] == 2'b11 && !t_i[g] && !c_i[g]));

        p_park_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pair_state_i[2*g +: 2] == 2'b01) |-> (t_i[g] && !c_i[g]));

        p_park_entry_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pair_state_i[2*g +: 2] == 2'b01 && $past(pair_state_i[2*g +: 2]) == 2'b00)
            |-> $past(t_i[g]));

        p_pd_over_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hold_pd_i && oe_i[g]) |-> pair_state_i[2*g+1]);
    end
endmodule

bind cpu_clk_gate_ctrl cpu_clk_gate_chk #(.N_OUT(N_OUT)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .oe_i         (oe_i),
    .pair_state_i (pair_state_o),
    .t_i          (clk_t_o),
    .c_i          (clk_c_o),
    .vco_en_i     (vco_en_o),
    .valid_i      (straps_valid_o),
    .fs_i         (fs_latched_o),
    .hold_pd_i    (hold_pd),
    .stop_req_i   (stop_req),
    .parked_i     (parked)
);

// File: tb/test_cpu_clk_gate_ctrl.sv
module test_cpu_clk_gate_ctrl;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         pgpd;
    logic         stop_n;
    logic [2:0]   fs;
    logic         itp;
    logic [7:0]   stab;
    logic [N-1:0] oe, stp, stri, ptri;
    logic [2*N-1:0] pst;
    logic [N-1:0] t, c;
    logic         vco, valid, itpl;
    logic [2:0]   fsl;
    logic [8:0]   mhz;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    cpu_clk_gate_ctrl #(.N_OUT(N), .STAB_W(8), .PARK_CYC(2)) i_cpu_clk_gate_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .pgpd_i(pgpd), .stop_ni(stop_n),
        .fs_strap_i(fs), .itp_strap_i(itp), .stab_cnt_i(stab),
        .oe_i(oe), .stoppable_i(stp), .stop_tri_i(stri), .pd_tri_i(ptri),
        .pair_state_o(pst), .clk_t_o(t), .clk_c_o(c), .vco_en_o(vco),
        .straps_valid_o(valid), .fs_latched_o(fsl), .itp_en_o(itpl), .cpu_mhz_o(mhz)
    );

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_err + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_mhz(input logic [2:0] code);
        case (code)
            3'd0: return 266;
            3'd1: return 133;
            3'd2: return 200;
            3'd3: return 166;
            3'd4: return 333;
            3'd5: return 100;
            3'd6: return 400;
            default: return 0;
        endcase
    endfunction

    // mode 0 run, 1 stop requested, 2 power-down
    function automatic logic [1:0] exp_st(input int mode, input int i);
        if (!oe[i]) return 2'b11;
        if (mode == 2) return ptri[i] ? 2'b11 : 2'b10;
        if (mode == 1 && stp[i]) return stri[i] ? 2'b11 : 2'b01;
        return 2'b00;
    endfunction

    function automatic bit all_match(input int mode);
        for (int i = 0; i < N; i++)
            if (pst[2*i +: 2] != exp_st(mode, i)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; pgpd = 1'b1; stop_n = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic set_cfg(input int k);
        for (int i = 0; i < N; i++) begin
            int cb;
            cb = (k + 5 * i) % 16;
            oe[i] = cb[0]; stp[i] = cb[1]; stri[i] = cb[2]; ptri[i] = cb[3];
        end
    endtask

    task automatic check_levels(input int mode, input string req);
        for (int i = 0; i < N; i++) begin
            logic [1:0] e;
            e = exp_st(mode, i);
            chk(pst[2*i +: 2] == e, req, pst[2*i +: 2], e);
            if (e == 2'b01 || e == 2'b10)
                chk(t[i] && !c[i], req, {t[i], c[i]}, 2);
            else if (e == 2'b11)
                chk(!t[i] && !c[i], req, {t[i], c[i]}, 0);
        end
    endtask

    task automatic check_run(input string req);
        logic [N-1:0] t0;
        tick();
        t0 = t;
        tick();
        for (int i = 0; i < N; i++) begin
            if (oe[i]) begin
                chk(pst[2*i +: 2] == 2'b00, {req, " R4 state"}, pst[2*i +: 2], 0);
                chk(t[i] != t0[i], {req, " R4 toggle"}, t[i], !t0[i]);
                chk(c[i] == !t[i], {req, " R4 complement"}, c[i], !t[i]);
            end else begin
                chk(pst[2*i +: 2] == 2'b11 && !t[i] && !c[i], {req, " R10 disabled"},
                    {pst[2*i +: 2], t[i], c[i]}, 12);
            end
        end
    endtask

    // counts sampled cycles with the oscillator on and all pairs still parked
    task automatic count_warm(input string req);
        int  warm;
        bit  done;
        warm = 0;
        done = 1'b0;
        for (int n = 0; n < 300 && !done; n++) begin
            tick();
            if (vco) begin
                if (all_match(2)) warm++;
                else done = 1'b1;
            end
        end
        chk(warm == int'(stab) + 1, req, warm, int'(stab) + 1);
    endtask

    task automatic stop_cycle(input bit hold_into_pd);
        logic [2*N-1:0] pst_prev;
        logic [N-1:0]   t_prev;
        int             n;
        bit             done;
        tick();
        pst_prev = pst; t_prev = t;
        stop_n = 1'b0;
        for (int s = 0; s < 8; s++) begin
            tick();
            for (int i = 0; i < N; i++)
                if (pst_prev[2*i +: 2] == 2'b00 && pst[2*i +: 2] == 2'b01)
                    chk(t_prev[i] == 1'b1, "R5 park from high", t_prev[i], 1);
            pst_prev = pst; t_prev = t;
        end
        check_levels(1, "R5 R6 R10 stop settled");
        if (hold_into_pd) return;
        stop_n = 1'b0;
        tick();
        pst_prev = pst;
        stop_n = 1'b1;
        n = 0;
        done = 1'b0;
        while (!done && n < 12) begin
            tick();
            n++;
            for (int i = 0; i < N; i++)
                if (pst_prev[2*i +: 2] != 2'b00 && pst[2*i +: 2] == 2'b00)
                    chk(t[i] == 1'b0, "R7 first running level", t[i], 0);
            pst_prev = pst;
            done = all_match(0);
        end
        chk(done && n <= 6 && (n >= 2 || n == 1 && !(|(oe & stp))), "R7 resume latency", n, 6);
    endtask

    task automatic pd_cycle(input bit stop_held);
        bit ok_prev;
        bit fell;
        int n;
        ok_prev = 1'b0;
        fell = 1'b0;
        pgpd = 1'b1;
        for (n = 0; n < 10 && !fell; n++) begin
            tick();
            if (!vco) begin
                fell = 1'b1;
                chk(ok_prev, "R8 parked before VCO off", ok_prev, 1);
            end
            ok_prev = all_match(2) && vco;
        end
        chk(fell && n <= 8, "R8 VCO off latency", n, 8);
        check_levels(2, stop_held ? "R9 pd over stop" : "R8 pd state");
        chk(vco == 1'b0, "R8 VCO stays off", vco, 0);
        if (stop_held) begin
            stop_n = 1'b1;
            repeat (2) tick();
        end
        pgpd = 1'b0;
        count_warm("R11 settle after pd exit");
        repeat (4) tick();
    endtask

    initial begin
        rst_n = 1'b0; pgpd = 1'b1; stop_n = 1'b1; fs = 3'd0; itp = 1'b0; stab = 8'd0;
        oe = '1; stp = '1; stri = '0; ptri = '0;

        // strap code sweep
        for (int code = 0; code < 8; code++) begin
            do_reset();
            fs = 3'(code); itp = code[0]; stab = 8'd0;
            repeat (3) tick();
            chk(!vco && !valid && pst == '1, "R2 dark before power-good", {vco, valid}, 0);
            pgpd = 1'b0;
            repeat (8) tick();
            chk(valid && fsl == 3'(code) && itpl == code[0], "R1 strap capture",
                {valid, fsl, itpl}, {1'b1, 3'(code), code[0]});
            chk(int'(mhz) == ref_mhz(3'(code)), "R1 frequency decode", mhz, ref_mhz(3'(code)));
        end

        // main configuration sweep
        set_cfg(0);
        stab = 8'd3;
        fs = 3'b010; itp = 1'b1;
        do_reset();
        tick();
        chk(!vco && pst == '1, "R2 reset state", {vco, pst}, 63);
        pgpd = 1'b0;
        count_warm("R3 settle after capture");
        fs = 3'b111; itp = 1'b0;
        repeat (4) tick();

        for (int k = 0; k < 16; k++) begin
            set_cfg(k);
            stab = 8'(k % 4);
            repeat (4) tick();
            check_run("run");
            stop_cycle(k[0]);
            if (!k[0]) check_run("after resume");
            pd_cycle(k[0]);
        end

        chk(fsl == 3'b010 && int'(mhz) == 200 && itpl, "R12 straps held", {fsl, mhz}, {3'b010, 9'd200});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule